// File: doc/BRIEF.md
# Register-Unrolled Bytecode Execution Unit

This block runs a subset of integer stack-machine bytecodes on a computing context that lives entirely in flip-flops. The context has four parts: an operand stack of eight 32-bit slots, eight 32-bit local variables, a constant pool base address and a bytecode program counter. The unit also holds the identifier of the method that is running. Because every stack slot is a register, an operation can read the top two entries, apply a transform and write the result back in a single clock.

A sequencer outside the block presents one opcode at a time, with up to two 16-bit immediates. It tags each opcode with the method identifier and program counter it expects the unit to hold. An opcode takes effect only when both tags match the live context and the unit is idle. Most opcodes finish in one clock. Multiply is iterative and holds a busy flag high until its product is written.

Calls, returns and explicit save/restore commands move whole contexts to and from a small bounded context stack, so recursion works up to that depth. A stack overflow or underflow of either stack sets a sticky error flag and leaves the context unchanged, including the program counter.

Top module: `bxu_top`

## Requirements
- R1: After reset, pc, mid, cp, depth, call_depth, err and busy are all 0, and tos reads 0. tos shows the top operand when depth is non-zero and 0 when the stack is empty.
- R2: An opcode is accepted only when op_valid is 1, busy is 0, op_mid equals mid and op_pc equals pc. Any other opcode leaves every output unchanged.
- R3: Data movement opcodes:
  - PUSH (code 1) pushes the sign-extended op_imm_a and advances pc by 3.
  - LOAD (2) pushes local[op_imm_a[2:0]] and advances pc by 2.
  - STORE (3) pops into local[op_imm_a[2:0]] and advances pc by 2.
  - DUP (4) copies the top entry and advances pc by 1.
  - POP (5) drops the top entry and advances pc by 1.
  - NOP (0) and every code above 25 only advance pc by 1.
- R4: Binary opcodes pop two entries and push one result, then advance pc by 1. Call the entry beneath the top A and the top entry B. ADD (6) gives A+B, SUB (7) gives A-B, AND (11) gives A&B, OR (12) gives A|B and XOR (14) gives A^B.
- R5: Shift opcodes use only B[4:0] as the shift count. SHL (15) shifts A left, SHR (16) shifts A right arithmetically and USHR (17) shifts A right logically. Each pops two entries, pushes one and advances pc by 1.
- R6: INC (9), DEC (10) and NOT (13) replace the top entry with top+1, top-1 and ~top, and advance pc by 1. IINC (18) adds the sign-extended op_imm_b to local[op_imm_a[2:0]] and advances pc by 3.
- R7: MUL (8) with at least two entries raises busy in the cycle after acceptance. It keeps busy high and the context frozen while busy, ignoring other opcodes. It then replaces the two entries with the low 32 bits of A*B, advances pc by 1 and drops busy.
- R8: IFZ (19) pops the top entry T and tests T against 0. IFCMP (20) pops A and B and tests A against B. Both are signed tests, with the condition code in op_imm_b[2:0]: 0 ==, 1 !=, 2 <, 3 >=, 4 >, 5 <=, 6 and 7 never taken. A taken branch sets pc to pc plus the signed op_imm_a. A branch not taken advances pc by 3.
- R9: GOTO (21) sets pc to pc plus the signed op_imm_a and leaves the stacks unchanged.
- R10: An opcode that would pop more entries than the stack holds, or push a ninth entry, sets err. The context (pc, stacks, locals) stays unchanged. err stays 1 until reset.
- R11: INVOKE (22) pops one argument and saves the caller context with pc advanced by 3 onto the context stack. It then starts a fresh context: mid equals op_imm_a[7:0], cp equals op_imm_b, pc is 0, the operand stack is empty, local 0 holds the argument and the other locals are 0.
- R12: RETURN (23) pops the callee's top entry, restores the most recently saved context and pushes that entry onto the restored operand stack.
- R13: CSAVE (24) copies the live context, with pc advanced by 1, onto the context stack and advances pc by 1. CRESTORE (25) reloads the most recent saved context exactly. call_depth counts the saved contexts, up to CALL_DEPTH (default 4). Saving past that depth, or restoring or returning with none saved, sets err and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode present |
| op_code | input | 6 | Opcode value |
| op_imm_a | input | 16 | First immediate (constant, local index, branch offset, callee id) |
| op_imm_b | input | 16 | Second immediate (condition code, increment, callee cp) |
| op_mid | input | 8 | Method identifier the opcode belongs to |
| op_pc | input | 16 | Program counter the opcode belongs to |
| busy | output | 1 | Multi-cycle operation in progress |
| err | output | 1 | Sticky stack error |
| pc | output | 16 | Live program counter |
| mid | output | 8 | Live method identifier |
| cp | output | 16 | Live constant pool base |
| depth | output | 4 | Operand stack occupancy |
| tos | output | 32 | Top operand, 0 when empty |
| call_depth | output | 3 | Saved contexts held |

## Verification
Directed sequences exercise each opcode family with operand values that tell the operand order apart. Subtract and the compare branches use unequal values, so a swapped operand pair gives a different result. A shift count above 31 shows whether only its low five bits are used, and a negative value shifted both ways separates the arithmetic shift from the logical one. The call tests nest invokes until the context stack overflows, and round-trip a save and restore. A long random opcode stream with random immediates, including mismatched method tags, is compared cycle by cycle against a bench model of the context.

// File: rtl/bxu_pkg.sv
package bxu_pkg;
  localparam int DW  = 32;
  localparam int SD  = 8;
  localparam int LD  = 8;
  localparam int SPW = $clog2(SD + 1);
  localparam int SIW = $clog2(SD);
  localparam int LIW = $clog2(LD);

  typedef enum logic [5:0] {
    OP_NOP = 6'd0, OP_PUSH = 6'd1, OP_LOAD = 6'd2, OP_STORE = 6'd3,
    OP_DUP = 6'd4, OP_POP = 6'd5, OP_ADD = 6'd6, OP_SUB = 6'd7,
    OP_MUL = 6'd8, OP_INC = 6'd9, OP_DEC = 6'd10, OP_AND = 6'd11,
    OP_OR = 6'd12, OP_NOT = 6'd13, OP_XOR = 6'd14, OP_SHL = 6'd15,
    OP_SHR = 6'd16, OP_USHR = 6'd17, OP_IINC = 6'd18, OP_IFZ = 6'd19,
    OP_IFCMP = 6'd20, OP_GOTO = 6'd21, OP_INVOKE = 6'd22, OP_RETURN = 6'd23,
    OP_CSAVE = 6'd24, OP_CRESTORE = 6'd25
  } op_e;

  typedef struct packed {
    logic [SD-1:0][DW-1:0] stk;
    logic [SPW-1:0]        sp;
    logic [LD-1:0][DW-1:0] loc;
    logic [15:0]           cp;
    logic [15:0]           pc;
    logic [7:0]            mid;
  } ctx_t;

  function automatic logic cond_hold(input logic [2:0] c,
                                     input logic [DW-1:0] a,
                                     input logic [DW-1:0] b);
    logic signed [DW-1:0] sa, sb;
    sa = $signed(a);
    sb = $signed(b);
    case (c)
      3'd0:    return sa == sb;
      3'd1:    return sa != sb;
      3'd2:    return sa <  sb;
      3'd3:    return sa >= sb;
      3'd4:    return sa >  sb;
      3'd5:    return sa <= sb;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bxu_alu.sv
module bxu_alu
  import bxu_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res
);
  localparam int SHW = $clog2(DW);
  logic [SHW-1:0] sh;
  assign sh = b[SHW-1:0];

  always_comb begin
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_SHL:  res = a << sh;
      OP_SHR:  res = $unsigned($signed(a) >>> sh);
      OP_USHR: res = a >> sh;
      OP_INC:  res = a + 1'b1;
      OP_DEC:  res = a - 1'b1;
      OP_NOT:  res = ~a;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/bxu_mul.sv
module bxu_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         done,
  output logic [W-1:0] prod
);
  localparam int CW = $clog2(W + 1);
  logic [W-1:0]  mc, mp;
  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc <= '0; mp <= '0; prod <= '0; cnt <= '0; run <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        mc <= a; mp <= b; prod <= '0; cnt <= CW'(W); run <= 1'b1;
      end else if (run) begin
        if (mp[0]) prod <= prod + mc;
        mc  <= mc << 1;
        mp  <= mp >> 1;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bxu_ctxstack.sv
module bxu_ctxstack
  import bxu_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  ctx_t          wdata,
  output ctx_t          rdata,
  output logic [CW-1:0] count
);
  ctx_t          mem [DEPTH];
  logic [CW-1:0] cm1;
  assign cm1   = count - 1'b1;
  assign rdata = mem[cm1[IW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[count[IW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (push) count <= count + 1'b1;
    else if (pop)  count <= count - 1'b1;
  end
endmodule

// File: rtl/bxu_top.sv
module bxu_top
  import bxu_pkg::*;
#(
  parameter int CALL_DEPTH = 4,
  localparam int CW = $clog2(CALL_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [5:0]    op_code,
  input  logic [15:0]   op_imm_a,
  input  logic [15:0]   op_imm_b,
  input  logic [7:0]    op_mid,
  input  logic [15:0]   op_pc,
  output logic          busy,
  output logic          err,
  output logic [15:0]   pc,
  output logic [7:0]    mid,
  output logic [15:0]   cp,
  output logic [SPW-1:0] depth,
  output logic [DW-1:0] tos,
  output logic [CW-1:0] call_depth
);
  localparam logic [SPW-1:0] SP_FULL = SPW'(SD);

  ctx_t cur, nxt, cwdata, ctop;
  op_e  op;
  logic acc, err_set, cpush, cpop, mstart, mdone, cfull, cempty;
  logic full, empty, two;
  logic [SPW-1:0] spm1, spm2;
  logic [SIW-1:0] i1, i2, ip, ir;
  logic [LIW-1:0] li;
  logic [DW-1:0]  top_v, nos_v, alu_a, alu_res, mprod, imm_a_x, imm_b_x;
  logic [15:0]    br_pc;

  assign op    = op_e'(op_code);
  assign acc   = op_valid && !busy && (op_mid == cur.mid) && (op_pc == cur.pc);
  assign spm1  = cur.sp - 1'b1;
  assign spm2  = cur.sp - 2'd2;
  assign i1    = spm1[SIW-1:0];
  assign i2    = spm2[SIW-1:0];
  assign ip    = cur.sp[SIW-1:0];
  assign ir    = ctop.sp[SIW-1:0];
  assign li    = op_imm_a[LIW-1:0];
  assign full  = (cur.sp == SP_FULL);
  assign empty = (cur.sp == '0);
  assign two   = (cur.sp >= SPW'(2));
  assign top_v = empty ? '0 : cur.stk[i1];
  assign nos_v = cur.stk[i2];
  assign imm_a_x = {{(DW-16){op_imm_a[15]}}, op_imm_a};
  assign imm_b_x = {{(DW-16){op_imm_b[15]}}, op_imm_b};
  assign br_pc   = cur.pc + op_imm_a;
  assign cfull   = (call_depth == CW'(CALL_DEPTH));
  assign cempty  = (call_depth == '0);
  assign alu_a   = (op == OP_INC || op == OP_DEC || op == OP_NOT) ? top_v : nos_v;

  bxu_alu u_alu (.op(op), .a(alu_a), .b(top_v), .res(alu_res));

  bxu_mul #(.W(DW)) u_mul (
    .clk(clk), .rst(rst), .start(mstart), .a(nos_v), .b(top_v),
    .done(mdone), .prod(mprod)
  );

  bxu_ctxstack #(.DEPTH(CALL_DEPTH)) u_cstk (
    .clk(clk), .rst(rst), .push(cpush), .pop(cpop), .wdata(cwdata),
    .rdata(ctop), .count(call_depth)
  );

  always_comb begin
    nxt     = cur;
    cwdata  = cur;
    err_set = 1'b0;
    cpush   = 1'b0;
    cpop    = 1'b0;
    mstart  = 1'b0;
    if (mdone) begin
      nxt.stk[i2] = mprod;
      nxt.sp      = spm1;
      nxt.pc      = cur.pc + 16'd1;
    end else if (acc) begin
      case (op)
        OP_PUSH: if (full) err_set = 1'b1;
                 else begin nxt.stk[ip] = imm_a_x; nxt.sp = cur.sp + 1'b1; nxt.pc = cur.pc + 16'd3; end
        OP_LOAD: if (full) err_set = 1'b1;
                 else begin nxt.stk[ip] = cur.loc[li]; nxt.sp = cur.sp + 1'b1; nxt.pc = cur.pc + 16'd2; end
        OP_STORE: if (empty) err_set = 1'b1;
                  else begin nxt.loc[li] = top_v; nxt.sp = spm1; nxt.pc = cur.pc + 16'd2; end
        OP_DUP: if (empty || full) err_set = 1'b1;
                else begin nxt.stk[ip] = top_v; nxt.sp = cur.sp + 1'b1; nxt.pc = cur.pc + 16'd1; end
        OP_POP: if (empty) err_set = 1'b1;
                else begin nxt.sp = spm1; nxt.pc = cur.pc + 16'd1; end
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR, OP_USHR:
          if (!two) err_set = 1'b1;
          else begin nxt.stk[i2] = alu_res; nxt.sp = spm1; nxt.pc = cur.pc + 16'd1; end
        OP_INC, OP_DEC, OP_NOT:
          if (empty) err_set = 1'b1;
          else begin nxt.stk[i1] = alu_res; nxt.pc = cur.pc + 16'd1; end
        OP_MUL: if (!two) err_set = 1'b1;
                else mstart = 1'b1;
        OP_IINC: begin
          nxt.loc[li] = cur.loc[li] + imm_b_x;
          nxt.pc      = cur.pc + 16'd3;
        end
        OP_IFZ: if (empty) err_set = 1'b1;
                else begin
                  nxt.sp = spm1;
                  nxt.pc = cond_hold(op_imm_b[2:0], top_v, '0) ? br_pc : cur.pc + 16'd3;
                end
        OP_IFCMP: if (!two) err_set = 1'b1;
                  else begin
                    nxt.sp = spm2;
                    nxt.pc = cond_hold(op_imm_b[2:0], nos_v, top_v) ? br_pc : cur.pc + 16'd3;
                  end
        OP_GOTO: nxt.pc = br_pc;
        OP_INVOKE: if (empty || cfull) err_set = 1'b1;
                   else begin
                     cpush     = 1'b1;
                     cwdata.sp = spm1;
                     cwdata.pc = cur.pc + 16'd3;
                     nxt        = '0;
                     nxt.mid    = op_imm_a[7:0];
                     nxt.cp     = op_imm_b;
                     nxt.loc[0] = top_v;
                   end
        OP_RETURN: if (empty || cempty || ctop.sp == SP_FULL) err_set = 1'b1;
                   else begin
                     cpop         = 1'b1;
                     nxt          = ctop;
                     nxt.stk[ir]  = top_v;
                     nxt.sp       = ctop.sp + 1'b1;
                   end
        OP_CSAVE: if (cfull) err_set = 1'b1;
                  else begin
                    cpush     = 1'b1;
                    cwdata.pc = cur.pc + 16'd1;
                    nxt.pc    = cur.pc + 16'd1;
                  end
        OP_CRESTORE: if (cempty) err_set = 1'b1;
                     else begin cpop = 1'b1; nxt = ctop; end
        default: nxt.pc = cur.pc + 16'd1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      err  <= 1'b0;
      busy <= 1'b0;
    end else begin
      cur  <= nxt;
      err  <= err | err_set;
      busy <= busy ? !mdone : mstart;
    end
  end

  assign pc    = cur.pc;
  assign mid   = cur.mid;
  assign cp    = cur.cp;
  assign depth = cur.sp;
  assign tos   = top_v;
endmodule

// File: rtl/bxu_chk.sv
module bxu_chk
  import bxu_pkg::*;
#(
  parameter int CD = 4,
  localparam int CW = $clog2(CD + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           op_valid,
  input logic [5:0]     op_code,
  input logic [7:0]     op_mid,
  input logic [15:0]    op_pc,
  input logic           busy,
  input logic           err,
  input logic [15:0]    pc,
  input logic [7:0]     mid,
  input logic [SPW-1:0] depth,
  input logic [CW-1:0]  call_depth
);
  logic hit;
  assign hit = op_valid && !busy && op_mid == mid && op_pc == pc;

  p_guard_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !hit) |=> ($stable(pc) && $stable(mid) && $stable(depth) && $stable(call_depth)));

  p_depth_bound_r3: assert property (@(posedge clk) disable iff (rst)
    depth <= SPW'(SD));

  p_mul_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (hit && op_code == 6'd8 && depth >= SPW'(2)) |=> busy);

  p_busy_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(pc) && $stable(depth)));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  p_call_bound_r13: assert property (@(posedge clk) disable iff (rst)
    call_depth <= CW'(CD));
endmodule

bind bxu_top bxu_chk #(.CD(CALL_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .op_mid(op_mid), .op_pc(op_pc), .busy(busy), .err(err), .pc(pc),
  .mid(mid), .depth(depth), .call_depth(call_depth)
);

// File: tb/bxu_top_tb.sv
module bxu_top_tb;
  import bxu_pkg::*;
  localparam int CD = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic op_valid = 1'b0;
  logic [5:0] op_code = '0;
  logic [15:0] op_imm_a = '0, op_imm_b = '0, op_pc = '0;
  logic [7:0] op_mid = '0;
  logic busy, err;
  logic [15:0] pc, cp;
  logic [7:0] mid;
  logic [SPW-1:0] depth;
  logic [DW-1:0] tos;
  logic [2:0] call_depth;

  always #2 clk = ~clk;

  bxu_top #(.CALL_DEPTH(CD)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_imm_a(op_imm_a), .op_imm_b(op_imm_b), .op_mid(op_mid), .op_pc(op_pc),
    .busy(busy), .err(err), .pc(pc), .mid(mid), .cp(cp), .depth(depth),
    .tos(tos), .call_depth(call_depth)
  );

  int   nvec = 0, nmis = 0;
  ctx_t m;
  ctx_t mstk [CD];
  int   mcnt;
  bit   merr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ref_cond(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    int sa, sb;
    sa = int'(a); sb = int'(b);
    case (c)
      0: return sa == sb;  1: return sa != sb;  2: return sa < sb;
      3: return sa >= sb;  4: return sa > sb;   5: return sa <= sb;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] mtos();
    return (m.sp == 0) ? 32'd0 : m.stk[int'(m.sp) - 1];
  endfunction

  task automatic model_step(input logic [5:0] code, input logic [15:0] a, input logic [15:0] b);
    ctx_t x;
    int sp, li;
    bit bad;
    logic [31:0] t, n, ax, bx;
    x = m; sp = int'(m.sp); li = int'(a[2:0]); bad = 0;
    t = (sp > 0) ? m.stk[sp-1] : 32'd0;
    n = (sp > 1) ? m.stk[sp-2] : 32'd0;
    ax = {{16{a[15]}}, a}; bx = {{16{b[15]}}, b};
    case (code)
      1:  if (sp == SD) bad = 1; else begin x.stk[sp] = ax; x.sp++; x.pc += 3; end
      2:  if (sp == SD) bad = 1; else begin x.stk[sp] = m.loc[li]; x.sp++; x.pc += 2; end
      3:  if (sp == 0) bad = 1; else begin x.loc[li] = t; x.sp--; x.pc += 2; end
      4:  if (sp == 0 || sp == SD) bad = 1; else begin x.stk[sp] = t; x.sp++; x.pc += 1; end
      5:  if (sp == 0) bad = 1; else begin x.sp--; x.pc += 1; end
      6, 7, 8, 11, 12, 14, 15, 16, 17:
          if (sp < 2) bad = 1;
          else begin
            case (code)
              6: x.stk[sp-2] = n + t;   7: x.stk[sp-2] = n - t;
              8: x.stk[sp-2] = n * t;   11: x.stk[sp-2] = n & t;
              12: x.stk[sp-2] = n | t;  14: x.stk[sp-2] = n ^ t;
              15: x.stk[sp-2] = n << t[4:0];
              16: x.stk[sp-2] = $unsigned($signed(n) >>> t[4:0]);
              default: x.stk[sp-2] = n >> t[4:0];
            endcase
            x.sp--; x.pc += 1;
          end
      9, 10, 13:
          if (sp == 0) bad = 1;
          else begin
            x.stk[sp-1] = (code == 9) ? t + 1 : (code == 10) ? t - 1 : ~t;
            x.pc += 1;
          end
      18: begin x.loc[li] = m.loc[li] + bx; x.pc += 3; end
      19: if (sp == 0) bad = 1;
          else begin x.sp--; x.pc = ref_cond(b[2:0], t, 0) ? m.pc + a : m.pc + 3; end
      20: if (sp < 2) bad = 1;
          else begin x.sp -= 2; x.pc = ref_cond(b[2:0], n, t) ? m.pc + a : m.pc + 3; end
      21: x.pc = m.pc + a;
      22: if (sp == 0 || mcnt == CD) bad = 1;
          else begin
            mstk[mcnt] = m; mstk[mcnt].sp--; mstk[mcnt].pc += 3; mcnt++;
            x = '0; x.mid = a[7:0]; x.cp = b; x.loc[0] = t;
          end
      23: if (sp == 0 || mcnt == 0 || int'(mstk[mcnt-1].sp) == SD) bad = 1;
          else begin
            mcnt--; x = mstk[mcnt]; x.stk[int'(x.sp)] = t; x.sp++;
          end
      24: if (mcnt == CD) bad = 1;
          else begin mstk[mcnt] = m; mstk[mcnt].pc += 1; mcnt++; x.pc += 1; end
      25: if (mcnt == 0) bad = 1; else begin mcnt--; x = mstk[mcnt]; end
      default: x.pc += 1;
    endcase
    if (bad) merr = 1; else m = x;
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " pc"}, 32'(pc), 32'(m.pc));
    chk({tag, " mid"}, 32'(mid), 32'(m.mid));
    chk({tag, " cp"}, 32'(cp), 32'(m.cp));
    chk({tag, " depth"}, 32'(depth), 32'(m.sp));
    chk({tag, " tos"}, tos, mtos());
    chk({tag, " err"}, 32'(err), 32'(merr));
    chk({tag, " call_depth"}, 32'(call_depth), 32'(mcnt));
    chk({tag, " busy"}, 32'(busy), 32'd0);
  endtask

  task automatic reset_all();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m = '0; mcnt = 0; merr = 0;
  endtask

  task automatic do_op(input logic [5:0] code, input logic [15:0] a, input logic [15:0] b,
                       input string tag, input bit wrong = 0);
    bit mulgo;
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_imm_a = a; op_imm_b = b;
    op_mid = wrong ? m.mid ^ 8'h5A : m.mid; op_pc = m.pc;
    mulgo = (code == 6'd8) && (m.sp >= 2) && !wrong;
    if (!wrong) model_step(code, a, b);
    @(negedge clk);
    op_valid = 1'b0;
    if (mulgo) begin
      chk("R7 busy after MUL accept", 32'(busy), 32'd1);
      for (int k = 0; k < 100 && busy; k++) @(negedge clk);
    end
    compare_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nmis++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    reset_all();
    // R1 reset state
    chk("R1 pc", 32'(pc), 0);  chk("R1 depth", 32'(depth), 0);
    chk("R1 tos", tos, 0);     chk("R1 err", 32'(err), 0);
    chk("R1 busy", 32'(busy), 0); chk("R1 call_depth", 32'(call_depth), 0);
    chk("R1 mid", 32'(mid), 0);   chk("R1 cp", 32'(cp), 0);

    // R4 subtract order
    do_op(OP_PUSH, 16'd7, 0, "R3 push");
    do_op(OP_PUSH, 16'd3, 0, "R3 push");
    do_op(OP_SUB, 0, 0, "R4 sub");
    chk("R4 7-3", tos, 32'd4); chk("R4 pc", 32'(pc), 32'd7);
    // R2 mismatched tag ignored
    do_op(OP_POP, 0, 0, "R2 wrong mid", 1);
    chk("R2 depth kept", 32'(depth), 32'd1);
    // R3 store/load/dup
    do_op(OP_STORE, 16'd5, 0, "R3 store");
    do_op(OP_LOAD, 16'd5, 0, "R3 load");
    do_op(OP_DUP, 0, 0, "R3 dup");
    do_op(OP_ADD, 0, 0, "R4 add");
    chk("R4 4+4", tos, 32'd8);
    // R5 shifts
    do_op(OP_PUSH, 16'hFFF0, 0, "R5 push");
    do_op(OP_PUSH, 16'd33, 0, "R5 push");
    do_op(OP_SHR, 0, 0, "R5 shr");
    chk("R5 sra by 33&31", tos, 32'hFFFFFFF8);
    do_op(OP_PUSH, 16'd4, 0, "R5 push");
    do_op(OP_USHR, 0, 0, "R5 ushr");
    chk("R5 lsr", tos, 32'h0FFFFFFF);
    // R6
    do_op(OP_NOT, 0, 0, "R6 not");
    chk("R6 not", tos, 32'hF0000000);
    do_op(OP_INC, 0, 0, "R6 inc");
    do_op(OP_DEC, 0, 0, "R6 dec");
    do_op(OP_DEC, 0, 0, "R6 dec");
    chk("R6 dec", tos, 32'hEFFFFFFF);
    do_op(OP_IINC, 16'd5, 16'hFFFE, "R6 iinc");
    do_op(OP_LOAD, 16'd5, 0, "R6 load");
    chk("R6 iinc", tos, 32'd2);
    // R7 multiply with an ignored op while busy
    do_op(OP_PUSH, 16'd1000, 0, "R7 push");
    do_op(OP_PUSH, 16'hFFFD, 0, "R7 push");
    @(negedge clk);
    op_valid = 1'b1; op_code = OP_MUL; op_mid = m.mid; op_pc = m.pc;
    model_step(OP_MUL, 0, 0);
    @(negedge clk);
    chk("R7 busy", 32'(busy), 1);
    op_code = OP_PUSH; op_pc = pc; op_imm_a = 16'd9;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R7 frozen depth", 32'(depth), 32'(int'(m.sp) + 1));
    for (int k = 0; k < 100 && busy; k++) @(negedge clk);
    compare_all("R7 mul");
    chk("R7 product", tos, 32'hFFFFF448);
    // R8 branches
    do_op(OP_IFZ, 16'd10, 16'd1, "R8 ifz ne taken");
    do_op(OP_PUSH, 16'd2, 0, "R8 push");
    do_op(OP_PUSH, 16'd9, 0, "R8 push");
    do_op(OP_IFCMP, 16'd40, 16'd4, "R8 ifcmp gt not taken");
    do_op(OP_PUSH, 16'd2, 0, "R8 push");
    do_op(OP_PUSH, 16'd9, 0, "R8 push");
    begin
      logic [15:0] p0; p0 = m.pc;
      do_op(OP_IFCMP, 16'hFFF0, 16'd2, "R8 ifcmp lt taken");
      chk("R8 taken pc", 32'(pc), 32'(p0 - 16'd16));
      p0 = m.pc;
      do_op(OP_GOTO, 16'd100, 0, "R9 goto");
      chk("R9 goto pc", 32'(pc), 32'(p0 + 16'd100));
    end
    // R11/R12 invoke and return
    do_op(OP_PUSH, 16'd42, 0, "R11 push");
    do_op(OP_INVOKE, 16'd5, 16'h0100, "R11 invoke");
    chk("R11 mid", 32'(mid), 5); chk("R11 depth", 32'(depth), 0);
    do_op(OP_LOAD, 16'd0, 0, "R11 arg");
    chk("R11 arg", tos, 42);
    do_op(OP_INC, 0, 0, "R12 inc");
    do_op(OP_RETURN, 0, 0, "R12 return");
    chk("R12 result", tos, 43); chk("R12 mid", 32'(mid), 0);
    // R13 save/restore, recursion overflow
    do_op(OP_CSAVE, 0, 0, "R13 save");
    do_op(OP_PUSH, 16'd77, 0, "R13 push");
    do_op(OP_CRESTORE, 0, 0, "R13 restore");
    chk("R13 restore tos", tos, 43);
    for (int i = 0; i < CD; i++) begin
      do_op(OP_DUP, 0, 0, "R13 dup");
      do_op(OP_INVOKE, 16'd9, 0, "R13 nest");
      do_op(OP_LOAD, 0, 0, "R13 arg");
    end
    chk("R13 full", 32'(call_depth), CD);
    do_op(OP_DUP, 0, 0, "R13 dup");
    do_op(OP_INVOKE, 16'd9, 0, "R13 overflow");
    chk("R13 err", 32'(err), 1);
    // R10 overflow and sticky error
    reset_all();
    for (int i = 0; i < SD + 1; i++) do_op(OP_PUSH, 16'(i), 0, "R10 fill");
    chk("R10 err", 32'(err), 1); chk("R10 depth", 32'(depth), SD);
    chk("R10 pc unchanged", 32'(pc), 32'(3 * SD));
    do_op(OP_POP, 0, 0, "R10 sticky");
    chk("R10 sticky", 32'(err), 1);
    reset_all();
    do_op(OP_ADD, 0, 0, "R10 underflow");
    chk("R10 underflow pc", 32'(pc), 0);

    // random phase
    reset_all();
    for (int i = 0; i < 600; i++) begin
      logic [5:0] c;
      logic [15:0] a, b;
      c = 6'($urandom_range(0, 27));
      a = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'($urandom_range(0, 40));
      b = 16'($urandom_range(0, 7));
      if (c == 6'd22 && a[7:0] == m.mid) a[0] = ~a[0];
      do_op(c, a, b, "R2 random", $urandom_range(0, 9) == 0);
      if (merr) reset_all();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule